// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block decides when a processor core leaves its normal instruction flow to service an exception. Seven request sources can be asserted as levels: an internal pending reset, a data abort, a fast interrupt, a normal interrupt, a prefetch abort, an undefined-instruction trap and a software interrupt. On each clock the block masks the two interrupt lines with its own I and F mask registers and picks the single highest-priority request that is still eligible. One cycle later it raises an entry strobe together with the vector fetch address, the processor mode to enter and an identifier for the exception taken.

The vector address is a base plus a per-exception offset. The base is either all zeros or 0xFFFF0000, chosen by a select input that is sampled in the cycle the decision is made. The mask registers follow fixed rules on entry. They can also be loaded by the core through a write port, which is how software re-enables interrupts. Saving return addresses, banking registers and returning from an exception belong to other blocks.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Requests are ranked, from highest to lowest: reset, data abort, FIQ, IRQ, prefetch abort, undefined instruction, software interrupt. When undefined instruction and software interrupt are both asserted, undefined instruction is taken.
- R2: The vector offset is 0x00 for reset, 0x04 for undefined instruction, 0x08 for software interrupt, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for IRQ and 0x1C for FIQ. Offset 0x14 is never produced.
- R3: The vector base is 0x00000000 when `hivec_sel` is 0 and 0xFFFF0000 when it is 1. The value used is the one present in the cycle before the strobe.
- R4: `mode_out` on entry is 10011 for reset and software interrupt, 11011 for undefined instruction, 10111 for either abort, 10010 for IRQ and 10001 for FIQ.
- R5: Every entry leaves `i_mask` at 1 from the strobe cycle on.
- R6: Only reset and FIQ entries set `f_mask`. Every other entry leaves `f_mask` at its previous value.
- R7: An IRQ request has no effect while `i_mask` is 1, and an FIQ request has no effect while `f_mask` is 1. A masked request does not block a lower-priority request.
- R8: When an eligible request is present at a clock edge and `entry_stb` is low, `entry_stb` is high in the following cycle, for exactly one cycle. No new entry is decided while `entry_stb` is high.
- R9: `rst_n` low asynchronously forces `entry_stb` to 0 and both masks to 1. After release, the first clock edge takes a reset entry: the vector is base+0x00 and the mode is 10011.
- R10: When `mask_wr` is 1 at an edge where no entry is decided, `i_mask` and `f_mask` take `mask_i_wr` and `mask_f_wr`. The write has no effect at an edge where an entry is decided.
- R11: `exc_id` equals the vector offset divided by four: 0 reset, 1 undefined, 2 software interrupt, 3 prefetch abort, 4 data abort, 6 IRQ, 7 FIQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; also the reset exception source |
| dabt_req | input | 1 | Data abort request |
| fiq_req | input | 1 | Fast interrupt request |
| irq_req | input | 1 | Normal interrupt request |
| pabt_req | input | 1 | Prefetch abort request |
| undef_req | input | 1 | Undefined instruction request |
| swi_req | input | 1 | Software interrupt request |
| mask_wr | input | 1 | Load the mask registers from the two values below |
| mask_i_wr | input | 1 | New I mask value |
| mask_f_wr | input | 1 | New F mask value |
| hivec_sel | input | 1 | Vector base select: 0 low, 1 high |
| entry_stb | output | 1 | One-cycle pulse marking an exception entry |
| exc_id | output | 3 | Identifier of the exception taken |
| vec_addr | output | ADDR_W | Vector fetch address |
| mode_out | output | 5 | Processor mode code on entry |
| i_mask | output | 1 | Current I mask bit |
| f_mask | output | 1 | Current F mask bit |

## Verification
On every cycle the assertions check several properties: the strobe is a single-cycle pulse, the reserved offset never appears, the vector base follows the select input, I is set after every entry, and F moves only for reset and FIQ. They also check that a data abort always outranks the interrupt lines and that a masked IRQ is never chosen. The full priority ladder and the undefined-over-software-interrupt tie-break are shown only by the bench's scenarios. The same goes for the behaviour of a masked request next to lower-priority ones, a mask write that coincides with an entry, and the reset entry after an asynchronous reset in mid-run.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int ID_W   = 3;
  localparam int MODE_W = 5;
  localparam int N_SRC  = 7;

  // Identifier equals vector offset / 4
  localparam logic [ID_W-1:0] ID_RST  = 3'd0;
  localparam logic [ID_W-1:0] ID_UND  = 3'd1;
  localparam logic [ID_W-1:0] ID_SWI  = 3'd2;
  localparam logic [ID_W-1:0] ID_PABT = 3'd3;
  localparam logic [ID_W-1:0] ID_DABT = 3'd4;
  localparam logic [ID_W-1:0] ID_RSVD = 3'd5;
  localparam logic [ID_W-1:0] ID_IRQ  = 3'd6;
  localparam logic [ID_W-1:0] ID_FIQ  = 3'd7;

  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;

  function automatic logic [4:0] vec_offset(input logic [ID_W-1:0] id);
    return {id, 2'b00};
  endfunction

  function automatic logic [MODE_W-1:0] entry_mode(input logic [ID_W-1:0] id);
    case (id)
      ID_UND:           return MODE_UND;
      ID_PABT, ID_DABT: return MODE_ABT;
      ID_IRQ:           return MODE_IRQ;
      ID_FIQ:           return MODE_FIQ;
      default:          return MODE_SVC;
    endcase
  endfunction

  function automatic logic entry_sets_f(input logic [ID_W-1:0] id);
    return (id == ID_RST) || (id == ID_FIQ);
  endfunction
endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick
  import exc_entry_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_pend,
  input  logic            dabt_req,
  input  logic            fiq_req,
  input  logic            irq_req,
  input  logic            pabt_req,
  input  logic            undef_req,
  input  logic            swi_req,
  input  logic            i_q,
  input  logic            f_q,
  input  logic            blocked,
  output logic            take,
  output logic [ID_W-1:0] sel_id
);
  // Index 0 is the highest priority
  localparam logic [ID_W-1:0] RANK [N_SRC] =
    '{ID_RST, ID_DABT, ID_FIQ, ID_IRQ, ID_PABT, ID_UND, ID_SWI};

  logic [N_SRC-1:0] eligible;

  always_comb begin
    eligible[0] = rst_pend;
    eligible[1] = dabt_req;
    eligible[2] = fiq_req & ~f_q;
    eligible[3] = irq_req & ~i_q;
    eligible[4] = pabt_req;
    eligible[5] = undef_req;
    eligible[6] = swi_req;
  end

  always_comb begin
    sel_id = ID_RST;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (eligible[k]) sel_id = RANK[k];
    end
    take = (|eligible) & ~blocked;
  end

  // R1: data abort outranks both interrupt lines and the lower sources
  a_r1_dabt_first: assert property (@(posedge clk) disable iff (!rst_n)
    take && dabt_req && !rst_pend |-> sel_id == ID_DABT);
  // R7: a masked IRQ is never the one chosen
  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    take && i_q |-> sel_id != ID_IRQ);
  // R7: a masked FIQ is never the one chosen
  a_r7_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    take && f_q |-> sel_id != ID_FIQ);
endmodule

// File: rtl/exc_mask_unit.sv
module exc_mask_unit
  import exc_entry_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [ID_W-1:0] sel_id,
  input  logic            ld,
  input  logic            ld_i,
  input  logic            ld_f,
  output logic            i_q,
  output logic            f_q
);
  logic set_f;
  assign set_f = entry_sets_f(sel_id);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q <= 1'b1;
      f_q <= 1'b1;
    end else if (take) begin
      i_q <= 1'b1;
      if (set_f) f_q <= 1'b1;
    end else if (ld) begin
      i_q <= ld_i;
      f_q <= ld_f;
    end
  end

  // R5: I is set after every entry
  a_r5_i_set: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> i_q);
  // R6: F is kept on entries other than reset and FIQ
  a_r6_f_kept: assert property (@(posedge clk) disable iff (!rst_n)
    take && !set_f |=> f_q == $past(f_q));
  // R6: F is set on reset and FIQ entries
  a_r6_f_set: assert property (@(posedge clk) disable iff (!rst_n)
    take && set_f |=> f_q);
  // R10: a mask write lands when no entry is decided
  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld && !take |=> (i_q == $past(ld_i)) && (f_q == $past(ld_f)));
endmodule

// File: rtl/exc_entry_reg.sv
module exc_entry_reg
  import exc_entry_pkg::*;
#(
  parameter int              ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] LO_BASE = '0,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ID_W-1:0]   sel_id,
  input  logic              hivec_sel,
  output logic              stb,
  output logic [ID_W-1:0]   id_q,
  output logic [ADDR_W-1:0] vec_q,
  output logic [MODE_W-1:0] mode_q
);
  logic [ADDR_W-1:0] base;
  assign base = hivec_sel ? HI_BASE : LO_BASE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb    <= 1'b0;
      id_q   <= ID_RST;
      vec_q  <= LO_BASE;
      mode_q <= MODE_SVC;
    end else begin
      stb <= take;
      if (take) begin
        id_q   <= sel_id;
        vec_q  <= base | ADDR_W'(vec_offset(sel_id));
        mode_q <= entry_mode(sel_id);
      end
    end
  end

  // R2: the reserved slot never appears on an entry
  a_r2_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (id_q != ID_RSVD) && (vec_q[4:0] != 5'h14));
  // R3: the base follows the select sampled at the decision edge
  a_r3_base: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (vec_q & ~ADDR_W'(5'h1C)) == ($past(hivec_sel) ? HI_BASE : LO_BASE));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] LO_BASE = '0,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dabt_req,
  input  logic              fiq_req,
  input  logic              irq_req,
  input  logic              pabt_req,
  input  logic              undef_req,
  input  logic              swi_req,
  input  logic              mask_wr,
  input  logic              mask_i_wr,
  input  logic              mask_f_wr,
  input  logic              hivec_sel,
  output logic              entry_stb,
  output logic [ID_W-1:0]   exc_id,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [MODE_W-1:0] mode_out,
  output logic              i_mask,
  output logic              f_mask
);
  // Named internal events for the checks
  logic            rst_pend;
  logic            take;
  logic [ID_W-1:0] sel_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pend <= 1'b1;
    else        rst_pend <= 1'b0;
  end

  exc_prio_pick u_pick (
    .clk(clk), .rst_n(rst_n), .rst_pend(rst_pend),
    .dabt_req(dabt_req), .fiq_req(fiq_req), .irq_req(irq_req),
    .pabt_req(pabt_req), .undef_req(undef_req), .swi_req(swi_req),
    .i_q(i_mask), .f_q(f_mask), .blocked(entry_stb),
    .take(take), .sel_id(sel_id)
  );

  exc_mask_unit u_mask (
    .clk(clk), .rst_n(rst_n), .take(take), .sel_id(sel_id),
    .ld(mask_wr), .ld_i(mask_i_wr), .ld_f(mask_f_wr),
    .i_q(i_mask), .f_q(f_mask)
  );

  exc_entry_reg #(.ADDR_W(ADDR_W), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)) u_ent (
    .clk(clk), .rst_n(rst_n), .take(take), .sel_id(sel_id),
    .hivec_sel(hivec_sel), .stb(entry_stb), .id_q(exc_id),
    .vec_q(vec_addr), .mode_q(mode_out)
  );

  // R8: the strobe never lasts two cycles
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    entry_stb |=> !entry_stb);
  // R9: the first edge after release takes the reset entry
  a_r9_reset_entry: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend |=> entry_stb && exc_id == ID_RST && i_mask && f_mask);
endmodule

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dabt = 0, fiq = 0, irq = 0, pabt = 0, und = 0, swi = 0;
  logic ld = 0, ld_i = 0, ld_f = 0, hiv = 0;
  logic        entry_stb, i_mask, f_mask;
  logic [2:0]  exc_id;
  logic [31:0] vec_addr;
  logic [4:0]  mode_out;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // model state
  logic m_i = 1, m_f = 1, m_stb = 0, m_pend = 1;
  logic e_stb = 0;
  logic [2:0] e_id = 0;
  logic [31:0] e_vec = 0;
  logic [4:0] e_mode = 0;

  always #10 clk = ~clk;  // 50 MHz

  exc_entry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .dabt_req(dabt), .fiq_req(fiq), .irq_req(irq),
    .pabt_req(pabt), .undef_req(und), .swi_req(swi), .mask_wr(ld),
    .mask_i_wr(ld_i), .mask_f_wr(ld_f), .hivec_sel(hiv),
    .entry_stb(entry_stb), .exc_id(exc_id), .vec_addr(vec_addr),
    .mode_out(mode_out), .i_mask(i_mask), .f_mask(f_mask)
  );

  function automatic logic [31:0] b_vec(input logic [2:0] id, input logic hi);
    logic [31:0] off;
    case (id)
      3'd0: off = 32'h00;  3'd1: off = 32'h04;  3'd2: off = 32'h08;
      3'd3: off = 32'h0C;  3'd4: off = 32'h10;  3'd6: off = 32'h18;
      default: off = 32'h1C;
    endcase
    return hi ? 32'hFFFF_0000 + off : off;
  endfunction

  function automatic logic [4:0] b_mode(input logic [2:0] id);
    if (id == 3'd0 || id == 3'd2) return 5'b10011;
    if (id == 3'd1) return 5'b11011;
    if (id == 3'd3 || id == 3'd4) return 5'b10111;
    if (id == 3'd6) return 5'b10010;
    return 5'b10001;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compute expected outputs after the next edge from the inputs now driven
  task automatic predict();
    logic tk;
    logic [2:0] pid;
    tk = 0; pid = 0;
    if (m_pend) tk = 1;
    else if (!m_stb) begin
      tk = 1;
      if (dabt) pid = 4;
      else if (fiq && !m_f) pid = 7;
      else if (irq && !m_i) pid = 6;
      else if (pabt) pid = 3;
      else if (und) pid = 1;
      else if (swi) pid = 2;
      else tk = 0;
    end
    e_stb = tk;
    if (tk) begin
      e_id = pid; e_vec = b_vec(pid, hiv); e_mode = b_mode(pid);
      m_i = 1;
      if (pid == 0 || pid == 7) m_f = 1;
    end else if (ld) begin
      m_i = ld_i; m_f = ld_f;
    end
    m_stb = tk; m_pend = 0;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R8 strobe"}, 32'(entry_stb), 32'(e_stb));
    chk({tag, " R5/R10 I"}, 32'(i_mask), 32'(m_i));
    chk({tag, " R6/R10 F"}, 32'(f_mask), 32'(m_f));
    if (e_stb) begin
      chk({tag, " R1/R11 id"}, 32'(exc_id), 32'(e_id));
      chk({tag, " R2/R3 vec"}, vec_addr, e_vec);
      chk({tag, " R4 mode"}, 32'(mode_out), 32'(e_mode));
    end
  endtask

  // inputs already driven at a negedge; advance one cycle and check
  task automatic step(input string tag);
    predict();
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic drive(input logic d, f, i, p, u, s);
    dabt = d; fiq = f; irq = i; pabt = p; und = u; swi = s;
  endtask

  task automatic do_reset(input logic hi);
    rst_n = 0; ld = 0;
    drive(0, 0, 0, 0, 0, 0);
    #3;
    chk("R9 async stb", 32'(entry_stb), 32'd0);
    chk("R9 async I", 32'(i_mask), 32'd1);
    chk("R9 async F", 32'(f_mask), 32'd1);
    m_i = 1; m_f = 1; m_stb = 0; m_pend = 1;
    @(negedge clk); @(negedge clk);
    rst_n = 1; hiv = hi;
    step("R9 reset entry");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; fails++;
      $display("FAIL R8 watchdog actual=%0d expected<=100000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset(0);
    step("R8 idle");
    ld = 1; ld_i = 0; ld_f = 0; step("R10 clear masks"); ld = 0;
    drive(1, 1, 1, 1, 1, 1); step("R1 all pending");
    step("R8 cooldown");
    step("R1 held abort");
    drive(0, 1, 1, 1, 0, 0);
    ld = 1; ld_i = 0; ld_f = 0; step("R10 reopen"); ld = 0;
    step("R6 fiq entry");
    step("R8 gap");
    step("R7 masked not blocking");
    drive(0, 0, 0, 0, 1, 1); step("R8 gap2");
    step("R1 undef over swi");
    drive(0, 0, 0, 0, 0, 0); hiv = 1;
    ld = 1; ld_i = 0; ld_f = 0; step("R10 reopen2"); ld = 0;
    drive(0, 0, 0, 0, 0, 1); step("R3 high base swi");
    drive(0, 0, 1, 0, 0, 0); step("R7 irq masked by I");
    hiv = 0; ld = 1; ld_i = 0; ld_f = 0; step("R10 clear for irq"); ld = 0;
    step("R6 irq keeps F");
    drive(0, 0, 0, 0, 0, 1);
    ld = 1; ld_i = 0; ld_f = 1; step("R8 gap3");
    step("R10 load ignored on entry");
    ld = 0; drive(0, 0, 0, 0, 0, 0);
    step("R11 idle");
    #5 do_reset(1);
    step("R9 after high reset");
    for (int n = 0; n < 4000; n++) begin
      logic uu;
      uu = ($urandom % 16) == 0;
      drive(($urandom % 20) == 0, ($urandom % 6) == 0, ($urandom % 4) == 0,
            ($urandom % 20) == 0, uu, !uu && ($urandom % 16) == 0);
      ld = ($urandom % 5) == 0; ld_i = $urandom; ld_f = $urandom;
      hiv = $urandom;
      step("random");
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule